// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value for precision timestamping. On each enabled cycle of its reference clock it adds a programmed clock period to the count. The period has two parts: a 10-bit whole-nanosecond part and a 32-bit binary fraction. The fraction goes into its own accumulator, and every carry out of that accumulator adds one more nanosecond. A reference clock whose period is not a whole number of nanoseconds therefore still tracks true time on average.

Software reaches the block through four 32-bit word registers, selected by a 2-bit word address. They are a control word, a fractional addend, and the low and high halves of the count. Reading the count low half first takes a snapshot of the high half, so the pair forms one coherent 64-bit value. Writing the count low half first stages it, and the write of the high half loads all 64 bits at once. When compensation mode is on, a new whole-nanosecond period is held back until the addend is written, so that both parts of the period change in the same cycle. The live count also drives a parallel output for timestamping logic.

Top module: `tod_frac_counter`

## Requirements
- R1: The register map is word address 0 for control, 1 for the fractional addend, 2 for the count low half and 3 for the count high half. In the control word, bits 1:0 are a stored source-select code, bit 2 is enable, bit 15 is compensation mode and bits 25:16 are the whole-nanosecond period. All other control bits read as zero.
- R2: After reset the count is zero, enable, compensation and source select are zero, the period reads 3 and the addend reads 0x0000000D.
- R3: On each cycle in which enable is set and no count load occurs, the count grows by the active whole period, plus one when the 32-bit fraction accumulator plus the active addend carries out. After N such cycles from a load, the count is the loaded value + N*period + floor(N*addend / 2^32).
- R4: While enable is clear, the count and the fraction accumulator keep their values.
- R5: With compensation mode set, a period written to the control word does not change the active period. The next write to the addend makes both the stored period and the new addend active together.
- R6: With compensation mode clear, a period written to the control word becomes active from the next cycle, with no addend write needed.
- R7: A read of the count low half returns the live low 32 bits and captures the high 32 bits at that same point. A later read of the high half returns the captured value, even after the live high half has moved on.
- R8: A write to the count low half only stages the data and leaves the count unchanged. A write to the high half loads {high data, staged low} into the count.
- R9: A count load clears the fraction accumulator. The loaded value appears in the next cycle without an increment, even when enable is set.
- R10: The control period field and the addend register read back the last values written, even while that period is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers the high-half snapshot) |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tod_ns | output | 64 | Live nanosecond count |

## Verification
Two events can land on the same edge: a count load and an enabled increment. The bench turns enable on and runs one tick so that the fraction accumulator holds half a nanosecond. It then writes the high half on the next edge while enable is still set, and allows exactly one more tick. It then lets one further single tick run, where a cleared accumulator produces its first carry. The two expected totals are computed from the loaded value. They differ from what a design would give if it both loaded and incremented, or if it kept the old fraction. The same arithmetic formula is swept over a grid of periods, fractions and tick counts.

// File: rtl/tod_pkg.sv
// Shared register map and control-word field positions for the
// fractional-period time-of-day counter. Assumes 32-bit register words.
package tod_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_ADDEND = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_CNT_HI = 2'd3
    } tod_reg_e;

    localparam int CTRL_SRC_LSB  = 0;
    localparam int CTRL_SRC_W    = 2;
    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_COMP_BIT = 15;
    localparam int CTRL_INT_LSB  = 16;

endpackage

// File: rtl/tod_regs.sv
// Control/period register bank. It holds the written control fields, the
// period as written (may be pending) and the period that is actually
// active, and it stages the count low half. It also decodes the count load.
// Assumes one write per cycle and INT_W <= 16, FRAC_W <= 32.
module tod_regs
    import tod_pkg::*;
#(
    parameter int INT_W    = 10,
    parameter int FRAC_W   = 32,
    parameter int RST_INT  = 3,
    parameter int RST_FRAC = 13,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tod_reg_e          addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              enable,
    output logic              comp_mode,
    output logic [CTRL_SRC_W-1:0] src_sel,
    output logic [INT_W-1:0]  int_written,
    output logic [INT_W-1:0]  int_active,
    output logic [FRAC_W-1:0] frac_active,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  load_val
);

    logic [DATA_W-1:0] lo_stage;
    logic              wr_ctrl;
    logic              wr_addend;

    // Decode the write strobes
    always_comb begin
        wr_ctrl   = wr_en && (addr == REG_CTRL);
        wr_addend = wr_en && (addr == REG_ADDEND);
        cnt_load  = wr_en && (addr == REG_CNT_HI);
        load_val  = {wdata, lo_stage};
    end

    // Register updates, including the deferred period switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable      <= 1'b0;
            comp_mode   <= 1'b0;
            src_sel     <= '0;
            int_written <= INT_W'(RST_INT);
            int_active  <= INT_W'(RST_INT);
            frac_active <= FRAC_W'(RST_FRAC);
            lo_stage    <= '0;
        end else if (wr_ctrl) begin
            enable      <= wdata[CTRL_EN_BIT];
            comp_mode   <= wdata[CTRL_COMP_BIT];
            src_sel     <= wdata[CTRL_SRC_LSB +: CTRL_SRC_W];
            int_written <= wdata[CTRL_INT_LSB +: INT_W];
            if (!wdata[CTRL_COMP_BIT]) begin
                int_active <= wdata[CTRL_INT_LSB +: INT_W];
            end
        end else if (wr_addend) begin
            frac_active <= wdata[FRAC_W-1:0];
            int_active  <= int_written;
        end else if (wr_en && (addr == REG_CNT_LO)) begin
            lo_stage    <= wdata;
        end
    end

    // R5: a compensated period write leaves the active period alone
    a_r5_defer_period: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_COMP_BIT]) |=> (int_active == $past(int_active)));

endmodule

// File: rtl/tod_accum.sv
// Count datapath: a 64-bit nanosecond counter plus a fraction accumulator
// whose carry adds one nanosecond. A load takes priority over a tick and
// clears the fraction. Assumes the period inputs are stable per cycle.
module tod_accum
    import tod_pkg::*;
#(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INT_W-1:0]  int_active,
    input  logic [FRAC_W-1:0] frac_active,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  cnt
);

    logic [FRAC_W-1:0] frac_acc;
    logic [FRAC_W:0]   frac_sum;

    // Fraction add with carry out
    always_comb begin
        frac_sum = {1'b0, frac_acc} + {1'b0, frac_active};
    end

    // Load, tick or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            frac_acc <= '0;
        end else if (cnt_load) begin
            cnt      <= load_val;
            frac_acc <= '0;
        end else if (enable) begin
            frac_acc <= frac_sum[FRAC_W-1:0];
            cnt      <= cnt + CNT_W'(int_active) + CNT_W'(frac_sum[FRAC_W]);
        end
    end

    // R3: a tick moves the count by the period or the period plus one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cnt_load) |=>
            ((cnt - $past(cnt)) >= CNT_W'($past(int_active))) &&
            ((cnt - $past(cnt)) <= CNT_W'($past(int_active)) + 1));

    // R4: disabled and not loading means the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !cnt_load) |=> $stable(cnt) && $stable(frac_acc));

    // R9: a load shows the loaded value with an empty fraction
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt == $past(load_val)) && (frac_acc == '0));

endmodule

// File: rtl/tod_rdmux.sv
// Read path: selects the register word for reg_rdata and keeps the high
// half snapshot that a read of the count low half takes. Reads have no
// other side effect. Assumes reads are decoded in the same cycle.
module tod_rdmux
    import tod_pkg::*;
#(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  tod_reg_e          addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              enable,
    input  logic              comp_mode,
    input  logic [CTRL_SRC_W-1:0] src_sel,
    input  logic [INT_W-1:0]  int_written,
    input  logic [FRAC_W-1:0] frac_active,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] hi_snap;

    // Capture the high half when the low half is read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_snap <= '0;
        end else if (rd_en && (addr == REG_CNT_LO)) begin
            hi_snap <= cnt[CNT_W-1:DATA_W];
        end
    end

    // Word selection for the read port
    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[CTRL_SRC_LSB +: CTRL_SRC_W] = src_sel;
                rdata[CTRL_EN_BIT]                = enable;
                rdata[CTRL_COMP_BIT]              = comp_mode;
                rdata[CTRL_INT_LSB +: INT_W]      = int_written;
            end
            REG_ADDEND: rdata[FRAC_W-1:0] = frac_active;
            REG_CNT_LO: rdata = cnt[DATA_W-1:0];
            REG_CNT_HI: rdata = hi_snap;
            default:    rdata = '0;
        endcase
    end

    // R7: a high read right after a low read returns that low read's high half
    a_r7_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == REG_CNT_LO)) |=>
            (!(addr == REG_CNT_HI) || (rdata == $past(cnt[CNT_W-1:DATA_W]))));

endmodule

// File: rtl/tod_frac_counter.sv
// Top of the fractional-period time-of-day counter. It ties together the
// register bank, the count datapath and the read path. Single clock domain;
// the reference clock is clk.
module tod_frac_counter
    import tod_pkg::*;
#(
    parameter int INT_W    = 10,
    parameter int FRAC_W   = 32,
    parameter int RST_INT  = 3,
    parameter int RST_FRAC = 13,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  tod_ns
);

    tod_reg_e              addr_e;
    logic                  enable;
    logic                  comp_mode;
    logic [CTRL_SRC_W-1:0] src_sel;
    logic [INT_W-1:0]      int_written;
    logic [INT_W-1:0]      int_active;
    logic [FRAC_W-1:0]     frac_active;
    logic                  cnt_load;
    logic [CNT_W-1:0]      load_val;
    logic [CNT_W-1:0]      cnt;

    // Cast the raw address onto the register enum
    always_comb begin
        addr_e = tod_reg_e'(reg_addr);
        tod_ns = cnt;
    end

    tod_regs #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .RST_INT(RST_INT), .RST_FRAC(RST_FRAC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(addr_e),
        .wdata(reg_wdata), .enable(enable), .comp_mode(comp_mode),
        .src_sel(src_sel), .int_written(int_written), .int_active(int_active),
        .frac_active(frac_active), .cnt_load(cnt_load), .load_val(load_val)
    );

    tod_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .enable(enable), .int_active(int_active),
        .frac_active(frac_active), .cnt_load(cnt_load), .load_val(load_val),
        .cnt(cnt)
    );

    tod_rdmux #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .addr(addr_e), .cnt(cnt),
        .enable(enable), .comp_mode(comp_mode), .src_sel(src_sel),
        .int_written(int_written), .frac_active(frac_active), .rdata(reg_rdata)
    );

endmodule

// File: tb/tb_tod_frac_counter.sv
module tb_tod_frac_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] tod_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [1:0] A_CTRL = 2'd0, A_ADD = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

    tod_frac_counter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tod_ns(tod_ns)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ctl(input bit en, input bit comp,
                                        input int per, input int src);
        return (32'(per) << 16) | (32'(comp) << 15) | (32'(en) << 2) | 32'(src & 3);
    endfunction

    task automatic chk(input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd64(output longint unsigned v);
        logic [31:0] lo, hi;
        rd(A_LO, lo);
        rd(A_HI, hi);
        v = {hi, lo};
    endtask

    task automatic load(input longint unsigned v);
        wr(A_LO, v[31:0]);
        wr(A_HI, v[63:32]);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        longint unsigned v, base;
        int pers[4];
        logic [31:0] fracs[5];
        int ticks[3];
        pers = '{1, 3, 7, 1023};
        fracs = '{32'h0, 32'hD, 32'h8000_0000, 32'hFFFF_FFFF, 32'h4000_0001};
        ticks = '{1, 5, 37};

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(A_CTRL, w); chk("R2 ctrl", w, 32'h0003_0000);
        rd(A_ADD, w);  chk("R2 addend", w, 32'hD);
        rd64(v);       chk("R2 count", v, 0);
        chk("R2 tod_ns", tod_ns, 0);

        // R1 control layout and source select readback
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, w); chk("R1 ctrl all ones", w, 32'h03FF_8007);
        wr(A_CTRL, ctl(0, 0, 3, 2));
        rd(A_CTRL, w); chk("R1 ctrl src", w, 32'h0003_0002);

        // R3 sweep of periods, fractions and tick counts; R4 hold
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 5; j++) begin
                for (int k = 0; k < 3; k++) begin
                    base = 64'h0000_0001_FFFF_FF00 + longint'(i * 1000 + j * 10 + k);
                    wr(A_CTRL, ctl(0, 0, pers[i], 0));
                    wr(A_ADD, fracs[j]);
                    load(base);
                    wr(A_CTRL, ctl(1, 0, pers[i], 0));
                    idle(ticks[k] - 1);
                    wr(A_CTRL, ctl(0, 0, pers[i], 0));
                    rd64(v);
                    chk("R3 sweep", v, base + longint'(ticks[k]) * longint'(pers[i])
                        + ((longint'(ticks[k]) * longint'(fracs[j])) >> 32));
                    if (k == 0) begin
                        idle(4);
                        rd64(w == 0 ? v : v);
                        chk("R4 hold", v, base + longint'(pers[i])
                            + (longint'(fracs[j]) >> 32));
                        chk("R4 tod_ns", tod_ns, v);
                    end
                end
            end
        end

        // R10 readback of addend
        rd(A_ADD, w); chk("R10 addend", w, 32'h4000_0001);

        // R5 deferred period, R10 pending period readback
        wr(A_CTRL, ctl(0, 0, 3, 0));
        wr(A_ADD, 32'h0);
        base = 64'h0000_0010_0000_0000;
        load(base);
        wr(A_CTRL, ctl(0, 1, 7, 0));
        rd(A_CTRL, w); chk("R10 pending period", w, ctl(0, 1, 7, 0));
        wr(A_CTRL, ctl(1, 1, 7, 0));
        idle(3);
        wr(A_CTRL, ctl(0, 1, 7, 0));
        rd64(v); chk("R5 old period kept", v, base + 12);
        wr(A_ADD, 32'h0);
        wr(A_CTRL, ctl(1, 1, 7, 0));
        idle(1);
        wr(A_CTRL, ctl(0, 1, 7, 0));
        rd64(v); chk("R5 switched on addend write", v, base + 26);

        // R6 immediate period without compensation
        wr(A_CTRL, ctl(0, 0, 5, 0));
        wr(A_CTRL, ctl(1, 0, 5, 0));
        idle(2);
        wr(A_CTRL, ctl(0, 0, 5, 0));
        rd64(v); chk("R6 immediate period", v, base + 41);

        // R8 low write alone does not move the count
        wr(A_LO, 32'h1234_5678);
        rd64(v); chk("R8 staged low only", v, base + 41);

        // R7 coherent read across a high-half rollover
        wr(A_CTRL, ctl(0, 0, 4, 0));
        wr(A_ADD, 32'h0);
        base = 64'h0000_0005_FFFF_FFF8;
        load(base);
        wr(A_CTRL, ctl(1, 0, 4, 0));
        rd(A_LO, w); chk("R7 live low", w, 32'hFFFF_FFF8);
        idle(3);
        rd(A_HI, w); chk("R7 snapshot high", w, 32'h5);
        wr(A_CTRL, ctl(0, 0, 4, 0));
        rd64(v); chk("R7 after rollover", v, base + 24);

        // R9 load while enabled: no increment, fraction cleared
        wr(A_CTRL, ctl(0, 0, 2, 0));
        wr(A_ADD, 32'h8000_0000);
        base = 64'h0000_0123_0000_0100;
        wr(A_CTRL, ctl(1, 0, 2, 0));
        wr(A_LO, base[31:0]);
        wr(A_HI, base[63:32]);
        wr(A_CTRL, ctl(0, 0, 2, 0));
        rd64(v); chk("R9 load wins over tick", v, base + 2);
        wr(A_CTRL, ctl(1, 0, 2, 0));
        wr(A_CTRL, ctl(0, 0, 2, 0));
        rd64(v); chk("R9 fraction cleared", v, base + 5);
        chk("R8 tod_ns after load", tod_ns, base + 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule